// File: doc/BRIEF.md
# Guarded Kernel-Clock Select Register

This block is a single memory-mapped configuration word that chooses the kernel clock for two serial ports and three timers. Each serial port has a 2-bit selector that picks one of four clock sources. Each timer has a 1-bit selector that moves the timer from its normal bus-derived clock to a fast clock taken from the PLL. The decoded selections leave the block on dedicated outputs and drive external clock multiplexers. Those multiplexers, their glitch-free switching and the PLL itself are outside this block.

The timer selectors are guarded. A timer can run from the fast clock only while two things hold: the system clock comes from the PLL, and the AHB ratio times the APB2 ratio is 1 or 2. Software can set a timer bit only while this holds. The hardware re-evaluates the guard on every clock. When it fails, the hardware drops every set timer bit back to 0. A dropped bit stays at 0 until software writes it again.

Software writes the whole word through `wr_en`/`wr_data`. `rd_data` always shows the current contents.

Top module: `clksel_cfg_reg`

## Requirements
- R1: After a synchronous reset every selector is 0 and `rd_data` reads 0x00000000. For the serial ports, 0 means bus clock. For the timers, 0 means the normal bus-derived clock.
- R2: Bits 17:16 (port 0) and bits 19:18 (port 1) hold the serial-port selectors and can always be written. The codes are 00 bus clock, 01 system clock, 10 slow external crystal and 11 fast internal RC. The written code appears on `rd_data` and on `port0_ksrc`/`port1_ksrc` on the clock edge after the write.
- R3: Timer selectors sit at bit 10 (timer 0), bit 11 (timer 1) and bit 13 (timer 2). A write of 1 is accepted when `sys_src` equals 2'b10 (PLL) and `ahb_ratio*apb2_ratio` is 1 or 2. `tmr_pll_sel[i]` then reads 1 on the next edge.
- R4: A write of 1 to a timer selector has no effect while the guard is false. This covers `sys_src` other than 2'b10, and products of 0, or of 3 and above.
- R5: When the guard is false at a clock edge, every timer selector is 0 after that edge, on `tmr_pll_sel` and on `rd_data`.
- R6: A timer selector that the hardware has cleared stays 0 when the guard becomes true again, unless software writes a 1 to it.
- R7: If a write of 1 meets a false guard in the same cycle, the clear wins and the bit ends at 0.
- R8: A write of 0 to a timer selector always takes effect.
- R9: Bits 31:20, 15:14, 12 and 9:0 are unused or reserved. They always read 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Whole-word write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register contents, with reserved bits at 0 |
| sys_src | input | 2 | Current system clock source; 2'b10 means PLL |
| ahb_ratio | input | AHB_RW (10) | Decoded AHB division ratio |
| apb2_ratio | input | APB_RW (5) | Decoded APB2 division ratio |
| port0_ksrc | output | 2 | Serial port 0 clock-mux select |
| port1_ksrc | output | 2 | Serial port 1 clock-mux select |
| tmr_pll_sel | output | 3 | Per-timer fast-clock select |

## Verification
The bench builds the block with its default widths: a 10-bit AHB ratio (up to 512) and a 5-bit APB2 ratio (up to 16). At these widths the full 15-bit product is reachable, so the bench can drive the guard through 1×1, 1×2, 2×1, 2×2, 1×4, a zero ratio and 512×16. It then checks that only products of 1 and 2 open the guard. With three timer bits it can also check that a clear hits all set bits together, and that a later rewrite restores one bit without bringing back the others.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int REG_W    = 32;
    localparam int NUM_PORT = 2;
    localparam int NUM_TMR  = 3;
    localparam int PORT_W   = 2;
    localparam int PORT_BASE = 16;

    // Serial-port kernel clock source codes
    typedef enum logic [PORT_W-1:0] {
        KSRC_BUS       = 2'b00,
        KSRC_CORE      = 2'b01,
        KSRC_SLOW_XTAL = 2'b10,
        KSRC_FAST_RC   = 2'b11
    } port_ksrc_e;

    // System clock source codes as reported by the clock tree
    typedef enum logic [1:0] {
        SYS_SRC_RC   = 2'b00,
        SYS_SRC_XTAL = 2'b01,
        SYS_SRC_PLL  = 2'b10,
        SYS_SRC_RSVD = 2'b11
    } sys_src_e;

    typedef struct packed {
        logic [NUM_PORT-1:0][PORT_W-1:0] port_sel;
        logic [NUM_TMR-1:0]              tmr_fast;
    } clksel_state_t;

    // LSB of serial-port selector i
    function automatic int port_lsb(input int idx);
        return PORT_BASE + PORT_W * idx;
    endfunction

    // Bit position of timer selector i
    function automatic int tmr_pos(input int idx);
        case (idx)
            0:       return 10;
            1:       return 11;
            default: return 13;
        endcase
    endfunction

    // Fold the state into the software-visible word
    function automatic logic [REG_W-1:0] pack_word(input clksel_state_t s);
        logic [REG_W-1:0] w;
        w = '0;
        for (int p = 0; p < NUM_PORT; p++) begin
            w[port_lsb(p) +: PORT_W] = s.port_sel[p];
        end
        for (int t = 0; t < NUM_TMR; t++) begin
            w[tmr_pos(t)] = s.tmr_fast[t];
        end
        return w;
    endfunction

    // Mask of all bits that can hold a 1
    function automatic logic [REG_W-1:0] live_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int p = 0; p < NUM_PORT; p++) begin
            m[port_lsb(p) +: PORT_W] = '1;
        end
        for (int t = 0; t < NUM_TMR; t++) begin
            m[tmr_pos(t)] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/clksel_guard.sv
module clksel_guard
    import clksel_pkg::*;
#(
    parameter int AHB_RW = 10,
    parameter int APB_RW = 5
) (
    input  logic [1:0]        sys_src,
    input  logic [AHB_RW-1:0] ahb_ratio,
    input  logic [APB_RW-1:0] apb2_ratio,
    output logic              fast_ok
);
    localparam int PROD_W = AHB_RW + APB_RW;

    logic [PROD_W-1:0] div_product;
    logic              on_pll;
    logic              div_small;

    always_comb begin
        div_product = PROD_W'(ahb_ratio) * PROD_W'(apb2_ratio);
        on_pll      = (sys_src == SYS_SRC_PLL);
        div_small   = (div_product == PROD_W'(1)) || (div_product == PROD_W'(2));
        fast_ok     = on_pll && div_small;
    end

    // R3 / R4: an open guard implies a non-zero ratio on both buses
    always_comb begin
        if (fast_ok) begin
            guard_ratio_nonzero_chk: assert ((ahb_ratio != '0) && (apb2_ratio != '0));
        end
    end

endmodule

// File: rtl/clksel_port_field.sv
module clksel_port_field
    import clksel_pkg::*;
#(
    parameter int LSB = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [PORT_W-1:0] sel
);
    port_ksrc_e sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= KSRC_BUS;
        end else if (wr_en) begin
            sel_q <= port_ksrc_e'(wr_data[LSB +: PORT_W]);
        end
    end

    assign sel = sel_q;

    // R2
    port_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (sel == $past(wr_data[LSB +: PORT_W])));

    // R2
    port_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(sel));

endmodule

// File: rtl/clksel_tmr_bit.sv
module clksel_tmr_bit
    import clksel_pkg::*;
#(
    parameter int POS = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             fast_ok,
    output logic             fast_q
);
    logic fast_d;

    always_comb begin
        fast_d = fast_q;
        if (wr_en) begin
            fast_d = wr_data[POS];
        end
        if (!fast_ok) begin
            fast_d = 1'b0;   // hardware clear outranks any write
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fast_q <= 1'b0;
        end else begin
            fast_q <= fast_d;
        end
    end

    // R3 / R4
    tmr_set_needs_guard_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fast_q) |-> $past(wr_en && wr_data[POS] && fast_ok));

    // R5 / R7
    tmr_clear_on_loss_chk: assert property (@(posedge clk) disable iff (rst)
        !fast_ok |=> !fast_q);

    // R6
    tmr_no_restore_chk: assert property (@(posedge clk) disable iff (rst)
        (!fast_q && !(wr_en && wr_data[POS])) |=> !fast_q);

    // R8
    tmr_zero_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[POS]) |=> !fast_q);

endmodule

// File: rtl/clksel_cfg_reg.sv
module clksel_cfg_reg
    import clksel_pkg::*;
#(
    parameter int AHB_RW = 10,
    parameter int APB_RW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic [1:0]        sys_src,
    input  logic [AHB_RW-1:0] ahb_ratio,
    input  logic [APB_RW-1:0] apb2_ratio,
    output logic [1:0]        port0_ksrc,
    output logic [1:0]        port1_ksrc,
    output logic [2:0]        tmr_pll_sel
);
    localparam logic [REG_W-1:0] LIVE = live_mask();

    clksel_state_t state;
    logic          fast_ok;

    clksel_guard #(
        .AHB_RW (AHB_RW),
        .APB_RW (APB_RW)
    ) u_guard (
        .sys_src    (sys_src),
        .ahb_ratio  (ahb_ratio),
        .apb2_ratio (apb2_ratio),
        .fast_ok    (fast_ok)
    );

    for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
        clksel_port_field #(
            .LSB (port_lsb(p))
        ) u_field (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en),
            .wr_data (wr_data),
            .sel     (state.port_sel[p])
        );
    end

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        clksel_tmr_bit #(
            .POS (tmr_pos(t))
        ) u_bit (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en),
            .wr_data (wr_data),
            .fast_ok (fast_ok),
            .fast_q  (state.tmr_fast[t])
        );
    end

    assign rd_data     = pack_word(state);
    assign port0_ksrc  = state.port_sel[0];
    assign port1_ksrc  = state.port_sel[1];
    assign tmr_pll_sel = state.tmr_fast;

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((rd_data & ~LIVE) == '0));

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (rd_data == '0));

endmodule

// File: tb/clksel_cfg_reg_bench.sv
module clksel_cfg_reg_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic [1:0]  sys_src;
    logic [9:0]  ahb_ratio;
    logic [4:0]  apb2_ratio;
    logic [1:0]  port0_ksrc;
    logic [1:0]  port1_ksrc;
    logic [2:0]  tmr_pll_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    clksel_cfg_reg u_clksel_cfg_reg (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .sys_src     (sys_src),
        .ahb_ratio   (ahb_ratio),
        .apb2_ratio  (apb2_ratio),
        .port0_ksrc  (port0_ksrc),
        .port1_ksrc  (port1_ksrc),
        .tmr_pll_sel (tmr_pll_sel)
    );

    localparam logic [31:0] TMR_BITS  = 32'h0000_2C00;
    localparam logic [31:0] PORT_BITS = 32'h000F_0000;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply a one-cycle write; returns at the negedge after the update edge
    task automatic do_write(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic set_guard(input logic [1:0] src, input logic [9:0] a, input logic [4:0] b);
        @(negedge clk);
        sys_src    = src;
        ahb_ratio  = a;
        apb2_ratio = b;
    endtask

    task automatic t_reset();
        do_write(32'hFFFF_FFFF);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset word", rd_data, 32'h0);
        chk("R1 reset timers", {29'h0, tmr_pll_sel}, 32'h0);
        chk("R1 reset ports", {28'h0, port1_ksrc, port0_ksrc}, 32'h0);
    endtask

    task automatic t_ports();
        set_guard(2'b00, 10'd8, 5'd4);
        do_write(32'h0008_0000);   // port1=10, port0=00
        chk("R2 port1 slow xtal", {30'h0, port1_ksrc}, 32'h2);
        chk("R2 port0 bus", {30'h0, port0_ksrc}, 32'h0);
        do_write(32'h0007_0000);   // port1=01, port0=11
        chk("R2 readback", rd_data, 32'h0007_0000);
        chk("R2 port0 fast rc", {30'h0, port0_ksrc}, 32'h3);
    endtask

    task automatic t_tmr_ok();
        set_guard(2'b10, 10'd1, 5'd2);
        do_write(32'h0000_2C00);
        chk("R3 all timers set", {29'h0, tmr_pll_sel}, 32'h7);
        chk("R3 readback", rd_data, 32'h0000_2C00);
        do_write(32'h0000_0800);
        chk("R8 write zero clears two", {29'h0, tmr_pll_sel}, 32'h2);
        do_write(32'h0);
    endtask

    task automatic t_tmr_blocked();
        set_guard(2'b01, 10'd1, 5'd1);   // not on PLL
        do_write(32'hFFFF_FFFF);
        chk("R4 off-PLL write", rd_data, PORT_BITS);
        set_guard(2'b10, 10'd2, 5'd2);   // product 4
        do_write(TMR_BITS);
        chk("R4 product 4", {29'h0, tmr_pll_sel}, 32'h0);
        set_guard(2'b10, 10'd0, 5'd1);   // product 0
        do_write(TMR_BITS);
        chk("R4 product 0", {29'h0, tmr_pll_sel}, 32'h0);
        set_guard(2'b10, 10'd512, 5'd16);
        do_write(TMR_BITS);
        chk("R4 product 8192", {29'h0, tmr_pll_sel}, 32'h0);
        set_guard(2'b10, 10'd2, 5'd1);   // product 2
        do_write(TMR_BITS);
        chk("R3 product 2", {29'h0, tmr_pll_sel}, 32'h7);
    endtask

    task automatic t_autoclear();
        set_guard(2'b10, 10'd1, 5'd1);
        do_write(TMR_BITS);
        chk("R3 set before loss", {29'h0, tmr_pll_sel}, 32'h7);
        set_guard(2'b10, 10'd1, 5'd4);   // guard lost
        @(negedge clk);
        chk("R5 cleared after loss", {29'h0, tmr_pll_sel}, 32'h0);
        chk("R5 word cleared", rd_data & TMR_BITS, 32'h0);
        set_guard(2'b10, 10'd1, 5'd1);
        @(negedge clk);
        @(negedge clk);
        chk("R6 no auto restore", {29'h0, tmr_pll_sel}, 32'h0);
        do_write(32'h0000_0400);
        chk("R6 rewrite one", {29'h0, tmr_pll_sel}, 32'h1);
        do_write(32'h0);
    endtask

    task automatic t_priority();
        set_guard(2'b10, 10'd1, 5'd1);
        @(negedge clk);
        wr_en     = 1'b1;
        wr_data   = TMR_BITS;
        sys_src   = 2'b00;                // guard drops in the same cycle
        @(negedge clk);
        wr_en     = 1'b0;
        chk("R7 clear wins", {29'h0, tmr_pll_sel}, 32'h0);
    endtask

    task automatic t_reserved();
        set_guard(2'b10, 10'd1, 5'd1);
        do_write(32'hFFF0_D3FF);          // only reserved/unused bits set
        chk("R9 reserved ignored", rd_data, 32'h0);
        do_write(32'hFFFF_FFFF);
        chk("R9 reserved read zero", rd_data, PORT_BITS | TMR_BITS);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0;
        sys_src = 2'b00; ahb_ratio = 10'd1; apb2_ratio = 5'd1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ports();
        t_tmr_ok();
        t_tmr_blocked();
        t_autoclear();
        t_priority();
        t_reserved();
        done = 1;
    end

    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule